// File: doc/BRIEF.md
# Configuration Target State Sequencer

This block is the control sequencer on the receiving side of a programmable device that is loaded over a serial link. It steps through four stages: loading, load error, start-up and user operation. It reports progress on an active-low status line and an active-high load-complete line, both open-drain style. It also keeps the user I/O in high impedance until user operation begins. An external host restarts the sequence by holding an active-low restart request low. The request is synchronized by two flops, and only a low pulse of at least a parameterized width counts.

The load itself is a count of serial-clock rising edges: after `NUM_BITS` of them the block raises load-complete. Content decoding, integrity checks and decompression are not modelled, so no data pin exists. A frame-error input aborts the load. The block either retries on its own or waits for the host, depending on `auto_restart_i`. Start-up begins after two serial-clock falling edges that follow load-complete. Start-up is then timed in one of two ways. It can count `INIT_CYC` cycles of the block's own clock. It can instead count `INIT_CYC` user-clock rising edges, and that count only starts after an enable delay of `UCLK_DLY` cycles.

Top module: `cfg_seq_top`

## Requirements
- R1: During and right after reset, status_no=0, conf_done_o=0, io_tristate_o=1 and user_mode_o=0. Once the synchronized request is high, loading starts (status_no=1).
- R2: A synchronized request low for MIN_LOW or more consecutive cycles sends the block to the reset stage from any stage. After release it starts a fresh load with the bit count cleared (status_no=1, conf_done_o=0).
- R3: A synchronized low pulse shorter than MIN_LOW cycles leaves the stage unchanged; after it, user operation and load-complete read as before.
- R4: While the synchronized request is low, status_no=0, conf_done_o=0 and io_tristate_o=1.
- R5: During loading, conf_done_o rises after exactly NUM_BITS serial-clock rising edges and not before.
- R6: A frame error during loading drives status_no low while conf_done_o stays low.
- R7: With auto_restart_i=1 the block leaves the error stage by itself and reloads from a zero count. With auto_restart_i=0 it stays in error, ignoring serial clocks, until a qualifying low request pulse.
- R8: Start-up begins only on the second serial-clock falling edge after load-complete. With uclk_sel_i=0, user_mode_o rises INIT_CYC clock cycles after that edge.
- R9: With uclk_sel_i=1, user-clock edges in the UCLK_DLY cycles after start-up begins are not counted. user_mode_o rises on the INIT_CYC-th counted user-clock rising edge.
- R10: Serial-clock activity after start-up begins, and user-clock activity when the internal clock is selected, have no effect.
- R11: io_tristate_o is low only in user operation with the synchronized request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the internal start-up clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reconfig_req_ni | input | 1 | Restart request, active low, asynchronous |
| sclk_i | input | 1 | Serial load clock, sampled by clk_i |
| frame_err_i | input | 1 | Frame error seen during loading |
| uclk_i | input | 1 | User start-up clock, sampled by clk_i |
| uclk_sel_i | input | 1 | 1: time start-up with uclk_i, 0: internal |
| auto_restart_i | input | 1 | 1: retry after an error without the host |
| status_no | output | 1 | Status, active low |
| conf_done_o | output | 1 | Load complete |
| io_tristate_o | output | 1 | 1: user I/O held in high impedance |
| user_mode_o | output | 1 | User operation reached |

## Verification
The bench builds the block with NUM_BITS=16, MIN_LOW=3, UCLK_DLY=5 and INIT_CYC=6. These small values let it run every path several times: both start-up clocks, errors with and without retry, and restarts from user operation. The short MIN_LOW places the one-cycle boundary between an ignored pulse and a qualifying one within a few cycles. UCLK_DLY=5 is long enough that two full user-clock pulses fall inside the enable window, so counting them by mistake would show up as early user mode.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET     = 3'd0,
    ST_CONFIG    = 3'd1,
    ST_ERROR     = 3'd2,
    ST_DONE_WAIT = 3'd3,
    ST_UDLY      = 3'd4,
    ST_INIT_USR  = 3'd5,
    ST_INIT_INT  = 3'd6,
    ST_USER      = 3'd7
  } cfg_state_e;

  function automatic logic done_stage(cfg_state_e s);
    return (s == ST_DONE_WAIT) || (s == ST_UDLY) || (s == ST_INIT_USR) ||
           (s == ST_INIT_INT) || (s == ST_USER);
  endfunction
endpackage

// File: rtl/cfg_req_filter.sv
module cfg_req_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic req_high_o,
  output logic restart_o
);
  localparam int LCW = $clog2(MIN_LOW + 1);

  logic          sync1_q, sync2_q;
  logic [LCW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= req_ni;
      sync2_q <= sync1_q;
    end
  end

  // saturating run length of the synchronized low level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       low_cnt_q <= '0;
    else if (sync2_q)                  low_cnt_q <= '0;
    else if (low_cnt_q != LCW'(MIN_LOW)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign req_high_o = sync2_q;
  // fires on the MIN_LOW-th consecutive low cycle
  assign restart_o  = !sync2_q && (low_cnt_q == LCW'(MIN_LOW - 1));
endmodule

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q && !sig_i;
    end else begin : g_rise
      assign edge_o = !prev_q && sig_i;
    end
  endgenerate
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int NUM_BITS = 64,
  parameter int MIN_LOW  = 4,
  parameter int UCLK_DLY = 8,
  parameter int INIT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reconfig_req_ni,
  input  logic sclk_i,
  input  logic frame_err_i,
  input  logic uclk_i,
  input  logic uclk_sel_i,
  input  logic auto_restart_i,
  output logic status_no,
  output logic conf_done_o,
  output logic io_tristate_o,
  output logic user_mode_o
);
  localparam int MAX_A = (NUM_BITS > INIT_CYC) ? NUM_BITS : INIT_CYC;
  localparam int MAX_V = (MAX_A > UCLK_DLY) ? MAX_A : UCLK_DLY;
  localparam int CW    = $clog2(MAX_V + 1);

  logic       req_high, restart;
  logic       sclk_rise, sclk_fall, uclk_rise;
  cfg_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  cfg_req_filter #(.MIN_LOW(MIN_LOW)) u_req (
    .clk_i, .rst_ni, .req_ni(reconfig_req_ni),
    .req_high_o(req_high), .restart_o(restart)
  );

  cfg_edge_det #(.FALLING(1'b0)) u_sclk_r (
    .clk_i, .rst_ni, .sig_i(sclk_i), .edge_o(sclk_rise)
  );
  cfg_edge_det #(.FALLING(1'b1)) u_sclk_f (
    .clk_i, .rst_ni, .sig_i(sclk_i), .edge_o(sclk_fall)
  );
  cfg_edge_det #(.FALLING(1'b0)) u_uclk_r (
    .clk_i, .rst_ni, .sig_i(uclk_i), .edge_o(uclk_rise)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (restart) begin
      state_d = ST_RESET;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_RESET: if (req_high) begin
          state_d = ST_CONFIG;
          cnt_d   = '0;
        end
        ST_CONFIG: begin
          if (frame_err_i) begin
            state_d = ST_ERROR;
            cnt_d   = '0;
          end else if (sclk_rise) begin
            if (cnt_q == CW'(NUM_BITS - 1)) begin
              state_d = ST_DONE_WAIT;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_ERROR: if (auto_restart_i) state_d = ST_RESET;
        ST_DONE_WAIT: if (sclk_fall) begin
          if (cnt_q == CW'(1)) begin
            state_d = uclk_sel_i ? ST_UDLY : ST_INIT_INT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_UDLY: begin
          if (cnt_q == CW'(UCLK_DLY - 1)) begin
            state_d = ST_INIT_USR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_INIT_USR: if (uclk_rise) begin
          if (cnt_q == CW'(INIT_CYC - 1)) begin
            state_d = ST_USER;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_INIT_INT: begin
          if (cnt_q == CW'(INIT_CYC - 1)) begin
            state_d = ST_USER;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_USER: state_d = ST_USER;
        default: state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // a low request overrides the open-drain outputs regardless of stage
  assign status_no     = req_high && (state_q != ST_RESET) && (state_q != ST_ERROR);
  assign conf_done_o   = req_high && done_stage(state_q);
  assign io_tristate_o = !(req_high && (state_q == ST_USER));
  assign user_mode_o   = (state_q == ST_USER);
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reconfig_req_ni,
  input logic       frame_err_i,
  input logic       status_no,
  input logic       conf_done_o,
  input logic       io_tristate_o,
  input logic       user_mode_o,
  input cfg_state_e state_q
);
  assert_forced_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reconfig_req_ni, 2) |-> !status_no && !conf_done_o && io_tristate_o);

  assert_done_needs_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_done_o |-> status_no);

  assert_err_drops_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIG) && frame_err_i |=> !status_no && !conf_done_o);

  assert_io_only_user_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_tristate_o |-> user_mode_o && conf_done_o && status_no);

  assert_user_exit_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(user_mode_o) |-> !status_no && !conf_done_o);
endmodule

bind cfg_seq_top cfg_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reconfig_req_ni(reconfig_req_ni),
  .frame_err_i(frame_err_i), .status_no(status_no), .conf_done_o(conf_done_o),
  .io_tristate_o(io_tristate_o), .user_mode_o(user_mode_o), .state_q(state_q)
);

// File: tb/cfg_seq_top_tb.sv
module cfg_seq_top_tb;
  localparam int NB = 16;
  localparam int ML = 3;
  localparam int UD = 5;
  localparam int IC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, sclk = 1'b0, ferr = 1'b0, uclk = 1'b0, usel = 1'b0, arst = 1'b0;
  logic status_n, done, tri_en, umode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    string    tag;
    logic [3:0] exp; // {status_no, conf_done_o, io_tristate_o, user_mode_o}
  } sb_item_t;
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  cfg_seq_top #(.NUM_BITS(NB), .MIN_LOW(ML), .UCLK_DLY(UD), .INIT_CYC(IC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reconfig_req_ni(req_n), .sclk_i(sclk),
    .frame_err_i(ferr), .uclk_i(uclk), .uclk_sel_i(usel), .auto_restart_i(arst),
    .status_no(status_n), .conf_done_o(done), .io_tristate_o(tri_en), .user_mode_o(umode)
  );

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if ({status_n, done, tri_en, umode} !== it.exp) begin
          errors++;
          $display("FAIL %s: got %b expected %b", it.tag,
                   {status_n, done, tri_en, umode}, it.exp);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string tag, logic s, logic d, logic t, logic u);
    sb_item_t it;
    it.tag = tag;
    it.exp = {s, d, t, u};
    sb_q.push_back(it);
  endtask

  task automatic sclk_pulse(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; tick(1);
      sclk = 1'b0; tick(1);
    end
  endtask

  task automatic uclk_pulse(int n);
    for (int i = 0; i < n; i++) begin
      uclk = 1'b1; tick(1);
      uclk = 1'b0; tick(1);
    end
  endtask

  task automatic req_pulse(int n);
    req_n = 1'b0; tick(n);
    req_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    tick(2);
    expect_out("R1 in reset", 0, 0, 1, 0);
    tick(1);
    rst_n = 1'b1;
    expect_out("R1 after release", 0, 0, 1, 0);
    tick(4);
    expect_out("R1 loading started", 1, 0, 1, 0);

    sclk_pulse(NB - 1);
    expect_out("R5 one bit short", 1, 0, 1, 0);
    sclk_pulse(1);
    expect_out("R5 load complete", 1, 1, 1, 0);
    tick(IC + 3);
    expect_out("R8 one falling edge only", 1, 1, 1, 0);
    sclk_pulse(1);
    tick(IC - 1);
    expect_out("R8 internal count short", 1, 1, 1, 0);
    tick(1);
    expect_out("R8 user mode internal", 1, 1, 0, 1);

    sclk_pulse(4);
    expect_out("R10 sclk in user mode", 1, 1, 0, 1);

    req_pulse(ML - 1);
    tick(1);
    expect_out("R4 forced during short pulse", 0, 0, 1, 1);
    tick(4);
    expect_out("R3 short pulse ignored", 1, 1, 0, 1);

    req_pulse(ML);
    tick(1);
    expect_out("R4 forced during long pulse", 0, 0, 1, 1);
    tick(5);
    expect_out("R2 restart from user", 1, 0, 1, 0);
    sclk_pulse(NB - 1);
    expect_out("R2 bit count cleared", 1, 0, 1, 0);
    sclk_pulse(1);
    expect_out("R2 reload complete", 1, 1, 1, 0);

    usel = 1'b1;
    sclk_pulse(1);
    uclk_pulse(2);
    tick(1);
    uclk_pulse(IC - 1);
    expect_out("R9 delay edges not counted", 1, 1, 1, 0);
    uclk_pulse(1);
    expect_out("R9 user mode via user clock", 1, 1, 0, 1);

    req_pulse(ML);
    tick(6);
    expect_out("R2 restart again", 1, 0, 1, 0);
    sclk_pulse(3);
    ferr = 1'b1; tick(1); ferr = 1'b0;
    tick(2);
    expect_out("R6 error status", 0, 0, 1, 0);
    tick(10);
    expect_out("R7 no auto retry holds", 0, 0, 1, 0);
    sclk_pulse(NB);
    expect_out("R7 error ignores sclk", 0, 0, 1, 0);
    req_pulse(ML);
    tick(6);
    expect_out("R7 host restart", 1, 0, 1, 0);

    arst = 1'b1;
    sclk_pulse(3);
    ferr = 1'b1; tick(1); ferr = 1'b0;
    expect_out("R6 error with auto retry", 0, 0, 1, 0);
    tick(3);
    expect_out("R7 auto retry reloads", 1, 0, 1, 0);
    sclk_pulse(NB - 1);
    expect_out("R7 retry count cleared", 1, 0, 1, 0);
    sclk_pulse(1);
    expect_out("R7 retry completes", 1, 1, 1, 0);

    usel = 1'b0;
    sclk_pulse(1);
    uclk_pulse(2);
    tick(1);
    expect_out("R10 uclk ignored internal", 1, 1, 1, 0);
    tick(1);
    expect_out("R10 internal user mode", 1, 1, 0, 1);

    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule